// File: doc/BRIEF.md
# Hierarchical Depth Tile Culling Unit

This block holds one conservative depth bound per screen tile: the farthest depth that any pixel of that tile can currently hold. Each incoming tile fragment carries the nearest and farthest depth of its primitive inside the tile. If its nearest depth lies behind the stored bound, no pixel of the fragment can pass a "less" depth test. The block then discards the fragment before pixel shading.

An accepted fragment that covers the whole tile can only lower the tile's content. The block therefore tightens the bound to the fragment's farthest depth, but only when no alpha test, stencil test or shader kill could leave pixels unwritten. When the depth compare direction changes, the stored bounds lose their meaning. The block then accepts every fragment until a table clear has completed.

The fine per-pixel depth stage may optionally report an exact per-tile maximum. The block uses it to restore a tight bound on tiles that were built up from several partial primitives. Culling stays correct without that input.

Requests use a valid/ready handshake. The decision appears one cycle after the handshake. The table read is registered, and a bypass lets back-to-back requests to the same tile see each other's updates.

Top module: `hz_cull_unit`

## Requirements
- R1: After reset is released, a two-stage reset synchronizer runs and then every table entry is filled with the far plane (all ones). `busy` stays high and `req_ready` low for TILE_COUNT+2 cycles, and `rsp_valid` stays low.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both high, and `req_ready` equals the inverse of `busy`. `rsp_valid` is high exactly in the cycle after a taken request.
- R3: Depths are unsigned, a smaller value is nearer, and the far plane is all ones. A fragment whose nearest depth is greater than the stored tile bound is discarded (`rsp_accept`=0). A nearest depth equal to or smaller than the bound is accepted.
- R4: An accepted fragment with `req_full`=0 leaves its tile entry unchanged.
- R5: An accepted fragment with `req_full`=1 and no side-effect flag replaces the entry with its farthest depth when that depth is smaller than the entry. Otherwise the entry keeps its value.
- R6: A fragment with `req_alpha`, `req_stencil` or `req_kill` set never changes the table.
- R7: A one-cycle pulse on `cmp_change` makes every later decision an accept. This lasts until the next clear has completed, after which culling resumes.
- R8: A `clr_req` pulse while idle raises `busy` from the next cycle for TILE_COUNT cycles and sets every entry to the far plane. No request is taken while `busy` is high.
- R9: A feedback write (`fb_valid`) replaces the entry of `fb_tile` only when `fb_zmax` is smaller than the entry. Feedback is ignored while `busy` is high.
- R10: When a feedback write and a tightening from the decision stage target the same tile in the same cycle, the tightening is dropped and only the feedback write is considered.
- R11: A request to the same tile as the request taken one cycle earlier is decided against the entry as updated by that earlier request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_tile | input | IDX_W | Tile index of the request |
| req_zmin | input | DEPTH_W | Nearest depth of the primitive in the tile |
| req_zmax | input | DEPTH_W | Farthest depth of the primitive in the tile |
| req_full | input | 1 | Primitive covers the whole tile |
| req_alpha | input | 1 | Alpha test enabled |
| req_stencil | input | 1 | Stencil test enabled |
| req_kill | input | 1 | Shader may kill pixels |
| rsp_valid | output | 1 | Decision valid, one cycle after the handshake |
| rsp_accept | output | 1 | 1 = pass to shading, 0 = discard |
| clr_req | input | 1 | Pulse: reset all tile entries to far plane |
| busy | output | 1 | Clear sequence in progress |
| cmp_change | input | 1 | Pulse: depth compare direction has changed |
| fb_valid | input | 1 | Exact tile maximum from fine depth stage is valid |
| fb_tile | input | IDX_W | Tile index of the feedback |
| fb_zmax | input | DEPTH_W | Exact farthest depth present in that tile |

## Verification
The properties assume that every request has `req_zmin` no greater than `req_zmax`. They also assume that `cmp_change` does not land in the same cycle that a clear completes. The bench builds depth pairs by adding a non-negative offset to the nearest value, so the first condition always holds. Tile indices cover the full index range because TILE_COUNT is a power of two. The bench pulses clear and compare-change only rarely and at random times. Its reference model follows the same priority rule, so a coincidence with clear completion is also predicted correctly.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Source selected for the next value of one tile entry.
  typedef enum logic [1:0] {
    SRC_KEEP  = 2'd0,
    SRC_CLEAR = 2'd1,
    SRC_FB    = 2'd2,
    SRC_REQ   = 2'd3
  } hz_wsrc_e;

  // Number of flops in the reset release synchronizer.
  localparam int unsigned HZ_SYNC_STAGES = 2;

endpackage

// File: rtl/hz_clear_seq.sv
module hz_clear_seq #(
  parameter  int unsigned TILES = 64,
  localparam int unsigned IW    = $clog2(TILES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic          done
);

  localparam logic [IW-1:0] LAST_IDX = IW'(TILES - 1);

  logic          act_q, act_d;
  logic [IW-1:0] idx_q, idx_d;

  // Next state: walk the table once, one entry per cycle.
  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    if (act_q) begin
      if (idx_q == LAST_IDX) begin
        act_d = 1'b0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end else if (start) begin
      act_d = 1'b1;
      idx_d = '0;
    end
  end

  // Reset starts a full clear, so the storage itself needs no reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b1;
      idx_q <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
    end
  end

  assign busy   = act_q;
  assign wr_en  = act_q;
  assign wr_idx = idx_q;
  assign done   = act_q && (idx_q == LAST_IDX);

endmodule

// File: rtl/hz_tile_store.sv
module hz_tile_store
  import hz_pkg::*;
#(
  parameter  int unsigned TILES = 64,
  parameter  int unsigned DW    = 24,
  localparam int unsigned IW    = $clog2(TILES)
) (
  input  logic          clk,
  input  logic          clr_we,
  input  logic [IW-1:0] clr_idx,
  input  logic          fb_we,
  input  logic [IW-1:0] fb_idx,
  input  logic [DW-1:0] fb_z,
  input  logic          rq_we,
  input  logic [IW-1:0] rq_idx,
  input  logic [DW-1:0] rq_z,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_q
);

  localparam logic [DW-1:0] FAR_Z = '1;

  // Next value of every entry; the registered read samples this so that
  // a write landing on the same edge is forwarded to the reader.
  logic [DW-1:0] ent_nxt [TILES];

  for (genvar g = 0; g < TILES; g++) begin : g_ent
    hz_wsrc_e      src;
    logic [DW-1:0] cur_q;
    logic [DW-1:0] nxt;

    // Priority: clear, then feedback (nearer only), then request update.
    always_comb begin
      src = SRC_KEEP;
      if (clr_we && (clr_idx == IW'(g))) begin
        src = SRC_CLEAR;
      end else if (fb_we && (fb_idx == IW'(g))) begin
        if (fb_z < cur_q) begin
          src = SRC_FB;
        end
      end else if (rq_we && (rq_idx == IW'(g))) begin
        src = SRC_REQ;
      end
    end

    always_comb begin
      case (src)
        SRC_CLEAR: nxt = FAR_Z;
        SRC_FB:    nxt = fb_z;
        SRC_REQ:   nxt = rq_z;
        default:   nxt = cur_q;
      endcase
    end

    always_ff @(posedge clk) begin
      if (src != SRC_KEEP) begin
        cur_q <= nxt;
      end
    end

    assign ent_nxt[g] = nxt;
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_q <= ent_nxt[rd_idx];
    end
  end

endmodule

// File: rtl/hz_decide.sv
module hz_decide #(
  parameter int unsigned DW = 24
) (
  input  logic          off,
  input  logic [DW-1:0] zmin,
  input  logic [DW-1:0] zmax,
  input  logic [DW-1:0] stored,
  input  logic          full,
  input  logic          side,
  output logic          accept,
  output logic          tighten
);

  logic not_behind;
  logic nearer_max;

  // "less" compare: equal to the stored bound is not behind it.
  assign not_behind = (zmin <= stored);
  assign nearer_max = (zmax < stored);

  assign accept  = off | not_behind;
  assign tighten = !off && full && !side && not_behind && nearer_max;

endmodule

// File: rtl/hz_cull_unit.sv
module hz_cull_unit
  import hz_pkg::*;
#(
  parameter  int unsigned TILE_COUNT = 64,
  parameter  int unsigned DEPTH_W    = 24,
  localparam int unsigned IDX_W      = $clog2(TILE_COUNT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [IDX_W-1:0]   req_tile,
  input  logic [DEPTH_W-1:0] req_zmin,
  input  logic [DEPTH_W-1:0] req_zmax,
  input  logic               req_full,
  input  logic               req_alpha,
  input  logic               req_stencil,
  input  logic               req_kill,
  output logic               rsp_valid,
  output logic               rsp_accept,
  input  logic               clr_req,
  output logic               busy,
  input  logic               cmp_change,
  input  logic               fb_valid,
  input  logic [IDX_W-1:0]   fb_tile,
  input  logic [DEPTH_W-1:0] fb_zmax
);

  // ---------------------------------------------------------------
  // Reset: asserted asynchronously, released on the clock.
  // ---------------------------------------------------------------
  logic [HZ_SYNC_STAGES-1:0] rsync_q;
  logic                      rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[HZ_SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = rsync_q[HZ_SYNC_STAGES-1];

  // ---------------------------------------------------------------
  // Clear sequencer
  // ---------------------------------------------------------------
  logic             clr_we;
  logic [IDX_W-1:0] clr_idx;
  logic             clr_done;

  hz_clear_seq #(
    .TILES (TILE_COUNT)
  ) u_clr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (clr_req),
    .busy   (busy),
    .wr_en  (clr_we),
    .wr_idx (clr_idx),
    .done   (clr_done)
  );

  assign req_ready = !busy;

  // ---------------------------------------------------------------
  // Decision stage registers
  // ---------------------------------------------------------------
  logic               take;
  logic               s_vld_q, s_vld_d;
  logic [IDX_W-1:0]   s_tile_q;
  logic [DEPTH_W-1:0] s_zmin_q, s_zmax_q;
  logic               s_full_q, s_side_q;
  logic               off_q, off_d;

  assign take = req_valid && req_ready;

  always_comb begin
    s_vld_d = take;
    off_d   = off_q;
    if (cmp_change) begin
      off_d = 1'b1;
    end else if (clr_done) begin
      off_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      s_vld_q <= 1'b0;
      off_q   <= 1'b0;
    end else begin
      s_vld_q <= s_vld_d;
      off_q   <= off_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      s_tile_q <= req_tile;
      s_zmin_q <= req_zmin;
      s_zmax_q <= req_zmax;
      s_full_q <= req_full;
      s_side_q <= req_alpha | req_stencil | req_kill;
    end
  end

  // ---------------------------------------------------------------
  // Tile table and decision
  // ---------------------------------------------------------------
  logic [DEPTH_W-1:0] stored_z;
  logic               dec_accept, dec_tighten;
  logic               fb_we, rq_we;

  assign fb_we = fb_valid && !busy;
  assign rq_we = s_vld_q && dec_tighten && !busy;

  hz_tile_store #(
    .TILES (TILE_COUNT),
    .DW    (DEPTH_W)
  ) u_store (
    .clk     (clk),
    .clr_we  (clr_we),
    .clr_idx (clr_idx),
    .fb_we   (fb_we),
    .fb_idx  (fb_tile),
    .fb_z    (fb_zmax),
    .rq_we   (rq_we),
    .rq_idx  (s_tile_q),
    .rq_z    (s_zmax_q),
    .rd_en   (take),
    .rd_idx  (req_tile),
    .rd_q    (stored_z)
  );

  hz_decide #(
    .DW (DEPTH_W)
  ) u_dec (
    .off     (off_q),
    .zmin    (s_zmin_q),
    .zmax    (s_zmax_q),
    .stored  (stored_z),
    .full    (s_full_q),
    .side    (s_side_q),
    .accept  (dec_accept),
    .tighten (dec_tighten)
  );

  assign rsp_valid  = s_vld_q;
  assign rsp_accept = s_vld_q & dec_accept;

endmodule

// File: rtl/hz_cull_chk.sv
module hz_cull_chk #(
  parameter int unsigned TILE_COUNT = 64
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_accept,
  input logic clr_req,
  input logic busy,
  input logic cmp_change
);

  localparam int unsigned SYNC_N   = 2;
  localparam int unsigned BUSY_MAX = TILE_COUNT + SYNC_N;
  localparam int unsigned CW       = $clog2(BUSY_MAX) + 1;

  logic [CW-1:0] busy_run;
  logic          busy_d;
  logic          off_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_run <= '0;
      busy_d   <= 1'b1;
      off_seen <= 1'b0;
    end else begin
      busy_run <= busy ? (busy_run + 1'b1) : '0;
      busy_d   <= busy;
      if (cmp_change) begin
        off_seen <= 1'b1;
      end else if (busy_d && !busy) begin
        off_seen <= 1'b0;
      end
    end
  end

  AST_RSP_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R2

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid); // R2

  AST_OFF_ACCEPTS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && off_seen) |-> rsp_accept); // R7

  AST_CLEAR_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !busy) |=> busy); // R8

  AST_CLEAR_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < CW'(BUSY_MAX))); // R8

endmodule

bind hz_cull_unit hz_cull_chk #(
  .TILE_COUNT (TILE_COUNT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_accept (rsp_accept),
  .clr_req    (clr_req),
  .busy       (busy),
  .cmp_change (cmp_change)
);

// File: tb/sim_hz_cull_unit.sv
module sim_hz_cull_unit;

  localparam int TCLK  = 10;
  localparam int TILES = 64;
  localparam int DW    = 24;
  localparam int IW    = 6;
  localparam int FAR   = 24'hFFFFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [IW-1:0] req_tile = '0;
  logic [DW-1:0] req_zmin = '0;
  logic [DW-1:0] req_zmax = '0;
  logic          req_full = 1'b0;
  logic          req_alpha = 1'b0;
  logic          req_stencil = 1'b0;
  logic          req_kill = 1'b0;
  logic          rsp_valid;
  logic          rsp_accept;
  logic          clr_req = 1'b0;
  logic          busy;
  logic          cmp_change = 1'b0;
  logic          fb_valid = 1'b0;
  logic [IW-1:0] fb_tile = '0;
  logic [DW-1:0] fb_zmax = '0;

  always #(TCLK/2) clk = ~clk;

  hz_cull_unit #(
    .TILE_COUNT (TILES),
    .DEPTH_W    (DW)
  ) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_tile    (req_tile),
    .req_zmin    (req_zmin),
    .req_zmax    (req_zmax),
    .req_full    (req_full),
    .req_alpha   (req_alpha),
    .req_stencil (req_stencil),
    .req_kill    (req_kill),
    .rsp_valid   (rsp_valid),
    .rsp_accept  (rsp_accept),
    .clr_req     (clr_req),
    .busy        (busy),
    .cmp_change  (cmp_change),
    .fb_valid    (fb_valid),
    .fb_tile     (fb_tile),
    .fb_zmax     (fb_zmax)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  int    cyc    = 0;
  bit    started = 1'b0;
  string tag = "R3";

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // ------------------------------------------------------------
  // Behavioural reference model, advanced on every rising edge
  // ------------------------------------------------------------
  int mref [TILES];
  int m_rst_cnt = 0;
  bit m_busy = 1'b1;
  int m_cnt  = 0;
  bit m_off  = 1'b0;
  bit m_pv   = 1'b0;
  int m_ptile, m_pzmin, m_pzmax;
  bit m_pfull, m_pside;

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n || m_rst_cnt < 2) begin
      if (!rst_n) m_rst_cnt = 0;
      else m_rst_cnt++;
      m_busy = 1'b1; m_cnt = 0; m_off = 1'b0; m_pv = 1'b0;
    end else begin
      bit old_busy;
      int old_cnt;
      bit tight;
      bit fb_same;
      old_busy = m_busy;
      old_cnt  = m_cnt;
      if (old_busy) begin
        mref[old_cnt] = FAR;
      end else begin
        tight   = m_pv && !m_off && m_pfull && !m_pside
                  && (m_pzmin <= mref[m_ptile]) && (m_pzmax < mref[m_ptile]);
        fb_same = fb_valid && (int'(fb_tile) == m_ptile);
        if (fb_valid && (int'(fb_zmax) < mref[fb_tile])) mref[fb_tile] = int'(fb_zmax);
        if (tight && !fb_same) mref[m_ptile] = m_pzmax;
      end
      if (cmp_change) m_off = 1'b1;
      else if (old_busy && old_cnt == TILES-1) m_off = 1'b0;
      if (old_busy) begin
        if (old_cnt == TILES-1) m_busy = 1'b0;
        else m_cnt = old_cnt + 1;
      end else if (clr_req) begin
        m_busy = 1'b1;
        m_cnt  = 0;
      end
      m_pv = req_valid && !old_busy;
      if (m_pv) begin
        m_ptile = int'(req_tile);
        m_pzmin = int'(req_zmin);
        m_pzmax = int'(req_zmax);
        m_pfull = req_full;
        m_pside = req_alpha | req_stencil | req_kill;
      end
    end
  end

  // Compare against the model away from the active edge.
  always @(negedge clk) begin
    if (started) begin
      chk("R8", "busy", int'(busy), int'(m_busy));
      chk("R2", "req_ready", int'(req_ready), int'(!m_busy));
      chk("R2", "rsp_valid", int'(rsp_valid), int'(m_pv));
      if (m_pv) chk(tag, "rsp_accept", int'(rsp_accept),
                    int'(m_off || (m_pzmin <= mref[m_ptile])));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  // ------------------------------------------------------------
  // Stimulus helpers
  // ------------------------------------------------------------
  task automatic drive_req(input int t, input int zmin, input int zmax,
                           input bit full, input bit a, input bit s, input bit k);
    req_valid   = 1'b1;
    req_tile    = IW'(t);
    req_zmin    = DW'(zmin);
    req_zmax    = DW'(zmax);
    req_full    = full;
    req_alpha   = a;
    req_stencil = s;
    req_kill    = k;
  endtask

  task automatic send(input string rq, input int t, input int zmin, input int zmax,
                      input bit full, input bit a, input bit s, input bit k, input bit exp);
    @(negedge clk);
    tag = rq;
    drive_req(t, zmin, zmax, full, a, s, k);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rq, "directed rsp_valid", int'(rsp_valid), 1);
    chk(rq, "directed accept", int'(rsp_accept), int'(exp));
  endtask

  task automatic feedback(input int t, input int z);
    @(negedge clk);
    fb_valid = 1'b1;
    fb_tile  = IW'(t);
    fb_zmax  = DW'(z);
    @(negedge clk);
    fb_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    int busy_len;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state and length of the initial fill
    chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);
    chk("R1", "req_ready after reset", int'(req_ready), 0);
    busy_len = 0;
    while (busy) begin
      busy_len++;
      @(negedge clk);
    end
    chk("R1", "busy cycles after reset", busy_len, TILES + 2);
    send("R1", 33, FAR, FAR, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);

    // R3: discard strictly behind, equal accepted
    send("R3", 5, 500, 1000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    send("R3", 5, 1001, 1200, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    send("R3", 5, 1000, 1200, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);

    // R4: partial coverage leaves the bound
    send("R4", 6, 10, 20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    send("R4", 6, 500, 600, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);

    // R5: full coverage tightens only when nearer
    send("R5", 7, 100, 300, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    send("R5", 7, 100, 400, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    send("R5", 7, 350, 360, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R6: side-effect flags block updates
    send("R6", 8, 10, 50, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    send("R6", 8, 10, 50, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    send("R6", 8, 10, 50, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    send("R6", 8, 100, 120, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);

    // R11: back-to-back to the same tile
    @(negedge clk);
    tag = "R11";
    drive_req(9, 100, 200, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    drive_req(9, 201, 250, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R11", "first accept", int'(rsp_accept), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11", "second sees update", int'(rsp_accept), 0);

    // R9: feedback applied only when nearer
    feedback(10, 70);
    send("R9", 10, 71, 80, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    feedback(10, 90);
    send("R9", 10, 80, 85, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R10: feedback wins over same-cycle tightening
    @(negedge clk);
    tag = "R10";
    drive_req(11, 100, 500, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    req_valid = 1'b0;
    fb_valid  = 1'b1;
    fb_tile   = IW'(11);
    fb_zmax   = DW'(600);
    chk("R10", "request accepted", int'(rsp_accept), 1);
    @(negedge clk);
    fb_valid = 1'b0;
    send("R10", 11, 550, 560, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);

    // R7: compare change disables culling
    @(negedge clk);
    cmp_change = 1'b1;
    @(negedge clk);
    cmp_change = 1'b0;
    send("R7", 5, 5000, 6000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    send("R7", 5, 1, 2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    send("R7", 5, 3, 4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);

    // R8: clear, requests held off while busy
    @(negedge clk);
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    tag = "R8";
    drive_req(5, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R8", "busy during clear", int'(busy), 1);
      chk("R8", "no response while busy", int'(rsp_valid), 0);
    end
    req_valid = 1'b0;
    wait_idle();
    send("R8", 7, 5000, 6000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    send("R7", 5, 0, 100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    send("R7", 5, 200, 300, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // Mixed random traffic on a few tiles, compared against the model
    tag = "R5";
    for (int i = 0; i < 3000; i++) begin
      int zlo;
      @(negedge clk);
      zlo         = int'($urandom % 1000);
      req_valid   = ($urandom % 2) == 0;
      req_tile    = IW'($urandom % 4);
      req_zmin    = DW'(zlo);
      req_zmax    = DW'(zlo + int'($urandom % 300));
      req_full    = ($urandom % 2) == 0;
      req_alpha   = ($urandom % 8) == 0;
      req_stencil = ($urandom % 8) == 0;
      req_kill    = ($urandom % 8) == 0;
      fb_valid    = ($urandom % 5) == 0;
      fb_tile     = IW'($urandom % 4);
      fb_zmax     = DW'($urandom % 1300);
      clr_req     = ($urandom % 150) == 0;
      cmp_change  = ($urandom % 300) == 0;
    end
    @(negedge clk);
    req_valid  = 1'b0;
    fb_valid   = 1'b0;
    clr_req    = 1'b0;
    cmp_change = 1'b0;
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule